// File: doc/BRIEF.md
# Write-Through Shadow Controller with One-Deep Posted Write Buffer

This block sits between a fast processor and a slow, strobe-paced memory bus. The processor keeps a private copy of slow memory in fast memory. Reads that fall in the shadowed space are answered from that copy at once and never use the slow bus. Writes go to the fast copy and are also queued for the slow side, so slow memory stays current for other readers of it, such as a display fetch engine.

The slow side is written through a single-entry posted buffer. The processor therefore pays no slow-bus time for an isolated write. A write that finds the buffer occupied stalls until the held entry is launched. A slow bus cycle can start only on a slow-cycle strobe, so sustained write throughput is one write per slow cycle.

A small window of device-register addresses is not shadowed. Reads there first let the buffer drain and then run a real slow-bus read, which keeps them in order with earlier writes. Writes there are forwarded only and leave fast memory untouched.

Top module: `wt_shadow_ctrl`

## Requirements
- R1: After reset the buffer is empty, `cpu_ready` is high while no request is pending, and `sb_stb` stays low until a write or device read has been accepted.
- R2: A read outside the device window is accepted in the cycle it is presented (`cpu_ready` high), returns `fm_rdata` for `cpu_addr`, and starts no slow-bus cycle.
- R3: A write outside the device window drives `fm_we` high with `cpu_addr`/`cpu_wdata` in its acceptance cycle, so an immediately following read of that address returns the new value.
- R4: Every accepted write, in either region, appears exactly once on the slow bus as a cycle with `sb_we`=1, and these cycles carry the same address and data in the same order as the writes were accepted.
- R5: A write inside the device window (address bits [11:8] equal to 4'hD with default parameters) does not assert `fm_we`.
- R6: A write presented while the buffer is empty is accepted in the same cycle without waiting.
- R7: A write presented while the buffer is occupied is held off (`cpu_ready` low) and is accepted exactly in the cycle in which `slow_tick` is high and the held entry is launched; the third of three back-to-back writes therefore waits exactly TICK_DIV-1 cycles when ticks arrive every TICK_DIV cycles.
- R8: `sb_stb` is high only in cycles in which `slow_tick` is high, and at most one slow cycle starts per strobe.
- R9: A read inside the device window starts its slow-bus read (`sb_stb`=1, `sb_we`=0) only once every earlier write has been launched, and is accepted at the next `slow_tick`, returning `sb_rdata` sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe marking each slow bus cycle boundary |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Read data, valid when `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Request accepted this cycle |
| fm_re | output | 1 | Fast-memory read enable |
| fm_we | output | 1 | Fast-memory write enable |
| fm_addr | output | AW | Fast-memory address |
| fm_wdata | output | DW | Fast-memory write data |
| fm_rdata | input | DW | Fast-memory read data, same-cycle |
| sb_stb | output | 1 | Slow bus cycle start |
| sb_we | output | 1 | Slow cycle is a write |
| sb_addr | output | AW | Slow bus address |
| sb_wdata | output | DW | Slow bus write data |
| sb_rdata | input | DW | Slow bus read data, sampled at the closing strobe |

## Verification
Isolated writes after an idle gap separate a posted buffer from one that always stalls. Three writes back to back expose the exact stall length that one-deep buffering imposes at a slow-strobe rate. A device read issued directly behind a write shows whether the read can overtake the queued write. A fast read of a just-written address shows whether the fast copy is updated at acceptance. A long random mix of regions, directions and idle gaps then checks that the slow-bus write stream matches the accepted write order with nothing lost or repeated.

// File: rtl/wt_shadow_pkg.sv
package wt_shadow_pkg;

   // device-read sequencer state
   typedef enum logic [0:0] {
      RD_IDLE = 1'b0,
      RD_BUSY = 1'b1
   } rd_state_e;

   // window decode variants
   localparam int DEC_MASK  = 0;
   localparam int DEC_RANGE = 1;

endpackage

// File: rtl/wt_region_decode.sv
module wt_region_decode #(
   parameter int              AW       = 12,
   parameter int              MODE     = 0,
   parameter logic [AW-1:0]   HW_BASE  = 12'hD00,
   parameter logic [AW-1:0]   HW_MASK  = 12'hF00,
   parameter logic [AW-1:0]   HW_LAST  = 12'hDFF
) (
   input  logic [AW-1:0] addr,
   output logic          is_hw
);
   import wt_shadow_pkg::*;

   generate
      if (MODE == DEC_MASK) begin : g_mask
         assign is_hw = ((addr & HW_MASK) == (HW_BASE & HW_MASK));
      end else if (MODE == DEC_RANGE) begin : g_range
         assign is_hw = (addr >= HW_BASE) && (addr <= HW_LAST);
      end else begin : g_bad
         $error("wt_region_decode: unsupported MODE");
         assign is_hw = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/wt_post_buf.sv
module wt_post_buf #(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_addr,
   input  logic [DW-1:0] ld_data,
   input  logic          launch,
   output logic          valid,
   output logic [AW-1:0] q_addr,
   output logic [DW-1:0] q_data
);

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
   } entry_t;

   entry_t ent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         ent_q <= '0;
      end else begin
         if (load) begin
            valid      <= 1'b1;
            ent_q.addr <= ld_addr;
            ent_q.data <= ld_data;
         end else if (launch) begin
            valid <= 1'b0;
         end
      end
   end

   assign q_addr = ent_q.addr;
   assign q_data = ent_q.data;

   // R7
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && valid) |-> launch);

   // R4
   launch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !load) |=> !valid);

endmodule

// File: rtl/wt_slow_seq.sv
module wt_slow_seq #(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_tick,
   input  logic          buf_valid,
   input  logic [AW-1:0] buf_addr,
   input  logic [DW-1:0] buf_data,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] sb_rdata,
   output logic          launch_wr,
   output logic          rd_done,
   output logic [DW-1:0] rd_data,
   output logic          sb_stb,
   output logic          sb_we,
   output logic [AW-1:0] sb_addr,
   output logic [DW-1:0] sb_wdata
);
   import wt_shadow_pkg::*;

   rd_state_e state_q;
   logic      rd_launch;

   // a queued write always owns the next strobe; a device read only takes one when nothing is queued
   assign launch_wr = slow_tick && buf_valid;
   assign rd_launch = slow_tick && !buf_valid && rd_req && (state_q == RD_IDLE);
   assign rd_done   = slow_tick && (state_q == RD_BUSY);
   assign rd_data   = sb_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RD_IDLE;
      end else begin
         case (state_q)
            RD_IDLE: if (rd_launch) state_q <= RD_BUSY;
            RD_BUSY: if (slow_tick) state_q <= RD_IDLE;
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign sb_stb   = launch_wr || rd_launch;
   assign sb_we    = launch_wr;
   assign sb_addr  = launch_wr ? buf_addr : rd_addr;
   assign sb_wdata = buf_data;

   // R8
   stb_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sb_stb |-> slow_tick);

   // R9
   read_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sb_stb && !sb_we) |-> !buf_valid);

   // R8
   single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({launch_wr, rd_launch}));

endmodule

// File: rtl/wt_shadow_ctrl.sv
module wt_shadow_ctrl #(
   parameter int              AW          = 12,
   parameter int              DW          = 8,
   parameter int              DECODE_MODE = 0,
   parameter logic [AW-1:0]   HW_BASE     = 12'hD00,
   parameter logic [AW-1:0]   HW_MASK     = 12'hF00,
   parameter logic [AW-1:0]   HW_LAST     = 12'hDFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_tick,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_ready,
   output logic          fm_re,
   output logic          fm_we,
   output logic [AW-1:0] fm_addr,
   output logic [DW-1:0] fm_wdata,
   input  logic [DW-1:0] fm_rdata,
   output logic          sb_stb,
   output logic          sb_we,
   output logic [AW-1:0] sb_addr,
   output logic [DW-1:0] sb_wdata,
   input  logic [DW-1:0] sb_rdata
);

   generate
      if (AW < 2) begin : g_aw_bad
         $error("wt_shadow_ctrl: AW must be at least 2");
      end
      if (DW < 1) begin : g_dw_bad
         $error("wt_shadow_ctrl: DW must be at least 1");
      end
   endgenerate

   logic          is_hw;
   logic          wr_req, rd_req;
   logic          buf_valid, buf_free, buf_load, launch_wr;
   logic [AW-1:0] buf_addr;
   logic [DW-1:0] buf_data;
   logic          rd_done;
   logic [DW-1:0] rd_data;

   wt_region_decode #(
      .AW(AW), .MODE(DECODE_MODE),
      .HW_BASE(HW_BASE), .HW_MASK(HW_MASK), .HW_LAST(HW_LAST)
   ) u_dec (
      .addr  (cpu_addr),
      .is_hw (is_hw)
   );

   assign wr_req   = cpu_req && cpu_we;
   assign rd_req   = cpu_req && !cpu_we;
   // entry frees in the very cycle its slow write launches
   assign buf_free = !buf_valid || launch_wr;
   assign buf_load = wr_req && buf_free;

   wt_post_buf #(.AW(AW), .DW(DW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (buf_load),
      .ld_addr (cpu_addr),
      .ld_data (cpu_wdata),
      .launch  (launch_wr),
      .valid   (buf_valid),
      .q_addr  (buf_addr),
      .q_data  (buf_data)
   );

   wt_slow_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .buf_valid (buf_valid),
      .buf_addr  (buf_addr),
      .buf_data  (buf_data),
      .rd_req    (rd_req && is_hw),
      .rd_addr   (cpu_addr),
      .sb_rdata  (sb_rdata),
      .launch_wr (launch_wr),
      .rd_done   (rd_done),
      .rd_data   (rd_data),
      .sb_stb    (sb_stb),
      .sb_we     (sb_we),
      .sb_addr   (sb_addr),
      .sb_wdata  (sb_wdata)
   );

   always_comb begin
      if (!cpu_req)       cpu_ready = 1'b1;
      else if (cpu_we)    cpu_ready = buf_free;
      else if (is_hw)     cpu_ready = rd_done;
      else                cpu_ready = 1'b1;
   end

   assign fm_re     = rd_req && !is_hw;
   assign fm_we     = buf_load && !is_hw;
   assign fm_addr   = cpu_addr;
   assign fm_wdata  = cpu_wdata;
   assign cpu_rdata = is_hw ? rd_data : fm_rdata;

   // R9
   hw_rd_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && is_hw && cpu_ready) |-> slow_tick);

   // R5
   hw_no_fast_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fm_we) |-> !is_hw);

endmodule

// File: tb/wt_shadow_ctrl_test.sv
module wt_shadow_ctrl_test;

   localparam int AW   = 12;
   localparam int DW   = 8;
   localparam int TDIV = 7;
   localparam int NRND = 300;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slow_tick = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_ready, fm_re, fm_we;
   logic [AW-1:0] fm_addr;
   logic [DW-1:0] fm_wdata, fm_rdata;
   logic          sb_stb, sb_we;
   logic [AW-1:0] sb_addr;
   logic [DW-1:0] sb_wdata, sb_rdata;

   wt_shadow_ctrl uut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .fm_re(fm_re), .fm_we(fm_we), .fm_addr(fm_addr), .fm_wdata(fm_wdata), .fm_rdata(fm_rdata),
      .sb_stb(sb_stb), .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata)
   );

   always #2.5 clk = ~clk;

   // fast memory model
   logic [DW-1:0] fmem [0:(1<<AW)-1];
   logic [DW-1:0] emem [0:(1<<AW)-1];
   assign fm_rdata = fmem[fm_addr];
   always @(posedge clk) if (fm_we) fmem[fm_addr] <= fm_wdata;

   int errors = 0, checks = 0, cyc = 0;
   int stb_seen = 0, wr_acc = 0, wr_seen = 0, rd_launches = 0;
   logic [AW+DW-1:0] exp_wq [$];
   logic [AW-1:0]    rd_lat = '0;

   function automatic logic is_hw_f(input logic [AW-1:0] a);
      return a[11:8] == 4'hD;
   endfunction

   function automatic logic [DW-1:0] slow_val(input logic [AW-1:0] a);
      return a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h3};
   endfunction

   assign sb_rdata = slow_val(rd_lat);

   task automatic chk(input logic ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic summary;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // slow strobe generator, every TDIV cycles
   int tcnt = 0;
   always @(negedge clk) begin
      slow_tick <= (tcnt == TDIV - 1);
      tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         summary();
      end
   end

   // slow-bus monitor, sampled late in the low phase
   always @(negedge clk) begin
      #2;
      if (rst_n && sb_stb) begin
         stb_seen++;
         chk(slow_tick === 1'b1, "R8 strobe aligned", slow_tick, 1);
         if (sb_we) begin
            if (exp_wq.size() == 0) begin
               chk(1'b0, "R4 unexpected slow write", sb_addr, 0);
            end else begin
               logic [AW+DW-1:0] e;
               e = exp_wq.pop_front();
               chk({sb_addr, sb_wdata} == e, "R4 write order", {sb_addr, sb_wdata}, e);
            end
            wr_seen++;
         end else begin
            rd_launches++;
            chk(exp_wq.size() == 0, "R9 read after drain", exp_wq.size(), 0);
            rd_lat = sb_addr;
         end
      end
   end

   int            o_wait;
   logic          o_tick, o_fmwe;
   logic [DW-1:0] o_rdata;

   task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      o_wait = 0;
      forever begin
         #1;
         if (cpu_ready) break;
         @(negedge clk);
         o_wait++;
      end
      o_tick = slow_tick; o_fmwe = fm_we; o_rdata = cpu_rdata;
      if (we) begin
         exp_wq.push_back({a, d});
         wr_acc++;
      end
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // run one operation and check it against the bench model
   task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int rd0;
      rd0 = rd_launches;
      op(we, a, d);
      if (we) begin
         if (o_wait > 0) chk(o_tick === 1'b1, "R7 accept on strobe", o_tick, 1);
         if (is_hw_f(a)) chk(o_fmwe === 1'b0, "R5 no fast write", o_fmwe, 0);
         else begin
            chk(o_fmwe === 1'b1, "R3 fast write", o_fmwe, 1);
            emem[a] = d;
         end
      end else if (is_hw_f(a)) begin
         chk(o_rdata == slow_val(a), "R9 device read data", o_rdata, slow_val(a));
         chk(o_tick === 1'b1, "R9 completes on strobe", o_tick, 1);
      end else begin
         chk(o_wait == 0, "R2 zero wait", o_wait, 0);
         chk(o_rdata == emem[a], "R2 shadow data", o_rdata, emem[a]);
         chk(rd_launches == rd0, "R2 no slow read", rd_launches, rd0);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < (1 << AW); i++) begin
         fmem[i] = '0;
         emem[i] = '0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      repeat (3 * TDIV) @(negedge clk);
      #1;
      chk(cpu_ready === 1'b1, "R1 ready after reset", cpu_ready, 1);
      chk(stb_seen == 0, "R1 no slow cycle", stb_seen, 0);

      // R6: isolated write posts without waiting
      do_op(1'b1, 12'h123, 8'h5C);
      chk(o_wait == 0, "R6 posted write", o_wait, 0);
      // R7: three back to back writes
      do_op(1'b1, 12'h124, 8'h11);
      do_op(1'b1, 12'hD10, 8'h22);
      do_op(1'b1, 12'h125, 8'h33);
      chk(o_wait == TDIV - 1, "R7 stall length", o_wait, TDIV - 1);
      // R3: read back just written address
      do_op(1'b0, 12'h125, 8'h00);
      // R9: device read right behind a write
      do_op(1'b1, 12'hD20, 8'h44);
      do_op(1'b0, 12'hD21, 8'h00);
      idle(2 * TDIV);

      for (int i = 0; i < NRND; i++) begin
         logic          we;
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         we = ($urandom % 2) == 0;
         d  = DW'($urandom);
         if (($urandom % 4) == 0) a = {4'hD, 8'($urandom)};
         else begin
            a = AW'($urandom);
            if (is_hw_f(a)) a[11:8] = 4'h2;
         end
         if (!we && (($urandom % 2) == 0)) a = exp_wq.size() > 0 ? exp_wq[$][AW+DW-1:DW] : a;
         do_op(we, a, d);
         if (($urandom % 5) == 0) idle($urandom % (2 * TDIV));
      end

      idle(3 * TDIV);
      chk(exp_wq.size() == 0, "R4 all writes reached slow bus", exp_wq.size(), 0);
      chk(wr_seen == wr_acc, "R4 no lost or extra write", wr_seen, wr_acc);
      summary();
   end

endmodule